// File: doc/BRIEF.md
# Saturating 40-bit Multiply-Accumulate Unit

This block is a fixed-point multiply-accumulate datapath for signal processing. Each clock it can accept one pair of 16-bit operands. It multiplies them and then loads the product into a 40-bit accumulator, adds it to the accumulator, or subtracts it from the accumulator. Each operand is taken as signed or unsigned on its own. A fractional mode doubles signed-by-signed products. The eight guard bits above bit 31 let long sums grow past 32 bits before the accumulator itself can wrap.

Every accepted operation also produces a result extracted from the new accumulator value. The result is either the upper half of the low 32 bits, with optional round-to-nearest, or the whole low 32 bits. The result can be clamped to the destination range, and a flag marks any clamp. A sticky flag records any overflow of the accumulator itself and holds until software clears it. The multiplier is registered, so an operation shows in the accumulator one clock after the edge that samples it.

Top module: `sat_mac40`

## Requirements
- R1: While `rst` is high at a clock edge, `acc_out`, `res_out`, `res_sat` and `acc_ovf` become zero, and any operation in flight is dropped.
- R2: An operation sampled with `in_valid` high at rising edge k updates `acc_out` at rising edge k+1. A new operation can be accepted at every edge.
- R3: `a_signed` and `b_signed` choose, per operation and per operand, between two's-complement (1) and unsigned (0) reading of `op_a` and `op_b`. The product is exact.
- R4: With `frac_mode` high and both operands signed, the product is doubled. The one case 0x8000 times 0x8000 gives 0x7FFFFFFF. `frac_mode` has no effect if either operand is unsigned.
- R5: `acc_op` 2'b00 loads the product into the accumulator, 2'b01 adds it, 2'b10 subtracts it, and 2'b11 leaves the accumulator unchanged. The product is sign-extended to 40 bits before use.
- R6: When `in_valid` is low, `acc_out`, `res_out` and `res_sat` keep their values, whatever the other inputs are.
- R7: If the exact result of an add or subtract lies outside the signed 40-bit range, `acc_out` takes it modulo 2^40 and `acc_ovf` is set. `acc_ovf` stays set through later operations.
- R8: `clr_ovf` high at an edge clears `acc_ovf`. If an overflow happens at that same edge, the flag is set instead.
- R9: With `out_wide` low, the result is (accumulator + (`rnd_en` ? 2^15 : 0)) shifted arithmetically right by 16. Without saturation its low 16 bits appear on `res_out`, sign-extended to 32 bits.
- R10: With `out_wide` high, the result is accumulator bits [31:0], and `rnd_en` has no effect.
- R11: With `sat_en` high, a result outside the signed 16-bit (narrow) or 32-bit (wide) range is replaced by that range's limit, sign-extended to 32 bits, and `res_sat` is 1. Otherwise `res_sat` is 0.
- R12: `res_out` and `res_sat` are updated at the same edge as the accumulator for every accepted operation, including 2'b11. They use the extraction controls sampled with that operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| op_a | input | 16 | First operand |
| op_b | input | 16 | Second operand |
| a_signed | input | 1 | First operand is two's complement |
| b_signed | input | 1 | Second operand is two's complement |
| frac_mode | input | 1 | Doubles signed-by-signed products |
| acc_op | input | 2 | 00 load, 01 add, 10 subtract, 11 keep |
| out_wide | input | 1 | 1: 32-bit result, 0: 16-bit result |
| rnd_en | input | 1 | Round-to-nearest for 16-bit result |
| sat_en | input | 1 | Clamp result to destination range |
| clr_ovf | input | 1 | Clears the sticky overflow flag |
| acc_out | output | 40 | Accumulator |
| res_out | output | 32 | Extracted result, sign-extended |
| res_sat | output | 1 | Result was clamped |
| acc_ovf | output | 1 | Sticky accumulator overflow |

## Verification
The multiplier is swept over every combination of eight boundary operands (zero, one, all ones, the most positive and most negative codes, one past the most negative, and two mixed patterns) with all four signedness settings and fractional mode both on and off. This exposes sign-versus-zero extension faults, a bad doubling, and a missing special case for the most negative operand squared. The operations cycle through load, add and subtract back to back. Many accumulator states, both small and well beyond 32 bits, are read out under all eight width, rounding and saturation settings using the keep operation. This tells truncation apart from rounding, and clamping apart from wrap-around. A long run of adds of the largest unsigned product drives the accumulator past its 40-bit limit to test wrap, stickiness, and a clear that falls on the same edge as an overflow. Idle cycles carry changing operands to show that unstrobed inputs are ignored.

// File: rtl/smac_pkg.sv
package smac_pkg;
    parameter int OP_W    = 16;
    parameter int GUARD_W = 8;
    parameter int ACC_W   = 40;
    localparam int PROD_W = ACC_W - GUARD_W;
    localparam int RES_W  = PROD_W;
    localparam int HALF_W = OP_W;

    typedef enum logic [1:0] {
        ACC_LOAD = 2'b00,
        ACC_ADD  = 2'b01,
        ACC_SUB  = 2'b10,
        ACC_KEEP = 2'b11
    } acc_op_e;

    typedef struct packed {
        logic wide;
        logic rnd;
        logic sat;
    } xfmt_t;

    typedef struct packed {
        logic                     vld;
        acc_op_e                  op;
        xfmt_t                    fmt;
        logic [ACC_W-1:0]         prod;
    } mstage_t;

    typedef struct packed {
        logic [RES_W-1:0] val;
        logic             clip;
    } xres_t;

    localparam logic [RES_W-1:0] NARROW_MAX = {{(RES_W-HALF_W+1){1'b0}}, {(HALF_W-1){1'b1}}};
    localparam logic [RES_W-1:0] NARROW_MIN = {{(RES_W-HALF_W+1){1'b1}}, {(HALF_W-1){1'b0}}};
    localparam logic [RES_W-1:0] WIDE_MAX   = {1'b0, {(RES_W-1){1'b1}}};
    localparam logic [RES_W-1:0] WIDE_MIN   = {1'b1, {(RES_W-1){1'b0}}};

    function automatic logic [OP_W:0] widen(input logic [OP_W-1:0] v, input logic sgn);
        return {sgn & v[OP_W-1], v};
    endfunction
endpackage

// File: rtl/smac_mult.sv
module smac_mult
    import smac_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [OP_W-1:0] op_a,
    input  logic [OP_W-1:0] op_b,
    input  logic            a_sgn,
    input  logic            b_sgn,
    input  logic            frac,
    input  acc_op_e         op,
    input  xfmt_t           fmt,
    output mstage_t         st
);
    localparam int FULL_W = 2 * (OP_W + 1);
    localparam logic [OP_W-1:0]  MIN_OP   = {1'b1, {(OP_W-1){1'b0}}};
    localparam logic [ACC_W-1:0] FRAC_TOP = {{(GUARD_W+1){1'b0}}, {(PROD_W-1){1'b1}}};

    logic signed [OP_W:0]     ax, bx;
    logic signed [FULL_W-1:0] full;
    logic [ACC_W-1:0]         prod_c;

    always_comb begin
        ax     = $signed(widen(op_a, a_sgn));
        bx     = $signed(widen(op_b, b_sgn));
        full   = ax * bx;
        prod_c = {{(ACC_W-FULL_W){full[FULL_W-1]}}, full};
        if (frac && a_sgn && b_sgn) begin
            if (op_a == MIN_OP && op_b == MIN_OP) prod_c = FRAC_TOP;
            else                                  prod_c = {prod_c[ACC_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else begin
            st.vld <= in_valid;
            if (in_valid) begin
                st.op   <= op;
                st.fmt  <= fmt;
                st.prod <= prod_c;
            end
        end
    end
endmodule

// File: rtl/smac_accum.sv
module smac_accum
    import smac_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             vld,
    input  acc_op_e          op,
    input  logic [ACC_W-1:0] prod,
    input  logic             clr_ovf,
    output logic [ACC_W-1:0] acc,
    output logic [ACC_W-1:0] acc_nx,
    output logic             ovf_evt,
    output logic             ovf_flag
);
    logic [ACC_W:0] ext_acc, ext_p, total;

    always_comb begin
        ext_acc = {acc[ACC_W-1], acc};
        ext_p   = {prod[ACC_W-1], prod};
        case (op)
            ACC_LOAD: total = ext_p;
            ACC_ADD:  total = ext_acc + ext_p;
            ACC_SUB:  total = ext_acc - ext_p;
            ACC_KEEP: total = ext_acc;
        endcase
        ovf_evt = vld && (total[ACC_W] != total[ACC_W-1]);
        acc_nx  = vld ? total[ACC_W-1:0] : acc;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc      <= '0;
            ovf_flag <= 1'b0;
        end else begin
            acc <= acc_nx;
            if (ovf_evt)      ovf_flag <= 1'b1;
            else if (clr_ovf) ovf_flag <= 1'b0;
        end
    end
endmodule

// File: rtl/smac_extract.sv
module smac_extract
    import smac_pkg::*;
(
    input  logic [ACC_W-1:0] acc,
    input  xfmt_t            fmt,
    output xres_t            res
);
    localparam int HI_W = ACC_W - HALF_W + 1;
    localparam logic [ACC_W:0] RND_K = {{(ACC_W+1-HALF_W){1'b0}}, 1'b1, {(HALF_W-1){1'b0}}};

    logic [ACC_W:0]  biased;
    logic [HI_W-1:0] hi;
    logic            fits_n, fits_w;

    always_comb begin
        biased = {acc[ACC_W-1], acc} + (fmt.rnd ? RND_K : '0);
        hi     = HI_W'($signed(biased) >>> HALF_W);
        fits_n = (&hi[HI_W-1:HALF_W-1]) | ~(|hi[HI_W-1:HALF_W-1]);
        fits_w = (&acc[ACC_W-1:RES_W-1]) | ~(|acc[ACC_W-1:RES_W-1]);
        res    = '0;
        if (fmt.wide) begin
            if (fmt.sat && !fits_w) begin
                res.val  = acc[ACC_W-1] ? WIDE_MIN : WIDE_MAX;
                res.clip = 1'b1;
            end else begin
                res.val  = acc[RES_W-1:0];
            end
        end else begin
            if (fmt.sat && !fits_n) begin
                res.val  = hi[HI_W-1] ? NARROW_MIN : NARROW_MAX;
                res.clip = 1'b1;
            end else begin
                res.val  = {{(RES_W-HALF_W){hi[HALF_W-1]}}, hi[HALF_W-1:0]};
            end
        end
    end
endmodule

// File: rtl/sat_mac40.sv
module sat_mac40
    import smac_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [OP_W-1:0]  op_a,
    input  logic [OP_W-1:0]  op_b,
    input  logic             a_signed,
    input  logic             b_signed,
    input  logic             frac_mode,
    input  logic [1:0]       acc_op,
    input  logic             out_wide,
    input  logic             rnd_en,
    input  logic             sat_en,
    input  logic             clr_ovf,
    output logic [ACC_W-1:0] acc_out,
    output logic [RES_W-1:0] res_out,
    output logic             res_sat,
    output logic             acc_ovf
);
    mstage_t          st;
    xfmt_t            fmt_in;
    xres_t            xr;
    logic [ACC_W-1:0] acc_q, acc_nx;
    logic             ovf_evt;
    logic [RES_W-1:0] res_q;
    logic             sat_q;

    always_comb begin
        fmt_in.wide = out_wide;
        fmt_in.rnd  = rnd_en;
        fmt_in.sat  = sat_en;
    end

    smac_mult u_mult (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .op_a(op_a), .op_b(op_b), .a_sgn(a_signed), .b_sgn(b_signed),
        .frac(frac_mode), .op(acc_op_e'(acc_op)), .fmt(fmt_in), .st(st)
    );

    smac_accum u_acc (
        .clk(clk), .rst(rst), .vld(st.vld), .op(st.op), .prod(st.prod),
        .clr_ovf(clr_ovf), .acc(acc_q), .acc_nx(acc_nx),
        .ovf_evt(ovf_evt), .ovf_flag(acc_ovf)
    );

    smac_extract u_ext (
        .acc(acc_nx), .fmt(st.fmt), .res(xr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
            sat_q <= 1'b0;
        end else if (st.vld) begin
            res_q <= xr.val;
            sat_q <= xr.clip;
        end
    end

    assign acc_out = acc_q;
    assign res_out = res_q;
    assign res_sat = sat_q;
endmodule

// File: rtl/sat_mac40_chk.sv
module sat_mac40_chk
    import smac_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [1:0]       acc_op,
    input logic [OP_W-1:0]  op_a,
    input logic             clr_ovf,
    input logic [ACC_W-1:0] acc_out,
    input logic [RES_W-1:0] res_out,
    input logic             res_sat,
    input logic             acc_ovf,
    input logic             s1_vld,
    input logic             s1_sat,
    input logic             ovf_evt
);
    AST_LOAD_ZERO_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (in_valid && acc_op == 2'b00 && op_a == '0) |=> ##1 (acc_out == '0)); // R2

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !s1_vld |=> ($stable(acc_out) && $stable(res_out) && $stable(res_sat))); // R6

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        (acc_ovf && !clr_ovf) |=> acc_ovf); // R7

    AST_OVF_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (clr_ovf && !ovf_evt) |=> !acc_ovf); // R8

    AST_SAT_LIMIT: assert property (@(posedge clk) disable iff (rst)
        res_sat |-> (res_out == NARROW_MAX || res_out == NARROW_MIN ||
                     res_out == WIDE_MAX   || res_out == WIDE_MIN)); // R11

    AST_NO_SAT_FLAG: assert property (@(posedge clk) disable iff (rst)
        (s1_vld && !s1_sat) |=> !res_sat); // R11
endmodule

bind sat_mac40 sat_mac40_chk u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .acc_op(acc_op), .op_a(op_a),
    .clr_ovf(clr_ovf), .acc_out(acc_out), .res_out(res_out), .res_sat(res_sat),
    .acc_ovf(acc_ovf), .s1_vld(st.vld), .s1_sat(st.fmt.sat), .ovf_evt(ovf_evt)
);

// File: tb/sat_mac40_test.sv
module sat_mac40_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid, a_signed, b_signed, frac_mode, out_wide, rnd_en, sat_en, clr_ovf;
    logic [15:0] op_a, op_b;
    logic [1:0]  acc_op;
    logic [39:0] acc_out;
    logic [31:0] res_out;
    logic        res_sat, acc_ovf;

    int    n_checks = 0;
    int    n_fail   = 0;
    string cur_req  = "R1";

    longint      m_acc;
    logic [31:0] m_res;
    bit          m_sat, m_ovf;
    bit          p_vld, p_wide, p_rnd, p_sat;
    logic [1:0]  p_op;
    longint      p_prod;

    always #(CLK_PERIOD/2) clk = ~clk;

    sat_mac40 uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .a_signed(a_signed), .b_signed(b_signed), .frac_mode(frac_mode),
        .acc_op(acc_op), .out_wide(out_wide), .rnd_en(rnd_en), .sat_en(sat_en),
        .clr_ovf(clr_ovf), .acc_out(acc_out), .res_out(res_out),
        .res_sat(res_sat), .acc_ovf(acc_ovf)
    );

    function automatic logic [15:0] pick(int i);
        case (i)
            0: return 16'h0000;
            1: return 16'h0001;
            2: return 16'hFFFF;
            3: return 16'h7FFF;
            4: return 16'h8000;
            5: return 16'h8001;
            6: return 16'h1234;
            default: return 16'hABCD;
        endcase
    endfunction

    function automatic longint f_prod(logic [15:0] a, logic [15:0] b, bit as, bit bs, bit fr);
        longint av, bv;
        av = as ? longint'($signed(a)) : longint'(a);
        bv = bs ? longint'($signed(b)) : longint'(b);
        if (fr && as && bs) begin
            if (a == 16'h8000 && b == 16'h8000) return 64'sh7FFFFFFF;
            return 2 * av * bv;
        end
        return av * bv;
    endfunction

    function automatic longint f_wrap(longint v);
        logic [39:0] t;
        t = v[39:0];
        return longint'($signed(t));
    endfunction

    task automatic f_extract(input longint a, input bit wd, input bit rn, input bit st,
                             output logic [31:0] r, output bit c);
        longint h;
        c = 1'b0;
        if (wd) begin
            if (st && a > 64'sd2147483647)       begin r = 32'h7FFFFFFF; c = 1'b1; end
            else if (st && a < -64'sd2147483648) begin r = 32'h80000000; c = 1'b1; end
            else r = a[31:0];
        end else begin
            h = (a + (rn ? 64'sd32768 : 64'sd0)) >>> 16;
            if (st && h > 64'sd32767)       begin r = 32'h00007FFF; c = 1'b1; end
            else if (st && h < -64'sd32768) begin r = 32'hFFFF8000; c = 1'b1; end
            else r = {{16{h[15]}}, h[15:0]};
        end
    endtask

    task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
        end
    endtask

    task automatic check_all();
        chk("acc_out", 64'(acc_out), 64'(m_acc[39:0]));
        chk("res_out", 64'(res_out), 64'(m_res));
        chk("res_sat", 64'(res_sat), 64'(m_sat));
        chk("acc_ovf", 64'(acc_ovf), 64'(m_ovf));
    endtask

    // one clock: check state after previous edge, drive, update model
    task automatic step(bit v, logic [15:0] a, logic [15:0] b, bit as, bit bs, bit fr,
                        logic [1:0] op, bit wd, bit rn, bit st, bit clr);
        longint nx;
        bit     evt;
        @(negedge clk);
        check_all();
        in_valid = v; op_a = a; op_b = b; a_signed = as; b_signed = bs;
        frac_mode = fr; acc_op = op; out_wide = wd; rnd_en = rn; sat_en = st;
        clr_ovf = clr;
        evt = 1'b0;
        if (p_vld) begin
            case (p_op)
                2'b00:   nx = p_prod;
                2'b01:   nx = m_acc + p_prod;
                2'b10:   nx = m_acc - p_prod;
                default: nx = m_acc;
            endcase
            if (nx > 64'sd549755813887 || nx < -64'sd549755813888) evt = 1'b1;
            m_acc = f_wrap(nx);
            f_extract(m_acc, p_wide, p_rnd, p_sat, m_res, m_sat);
        end
        if (evt)      m_ovf = 1'b1;
        else if (clr) m_ovf = 1'b0;
        p_vld = v; p_op = op; p_wide = wd; p_rnd = rn; p_sat = st;
        p_prod = f_prod(a, b, as, bs, fr);
        @(posedge clk);
    endtask

    task automatic idle(bit clr);
        step(1'b0, 16'h5A5A, 16'hC3C3, 1'b1, 1'b0, 1'b1, 2'b00, 1'b0, 1'b1, 1'b1, clr);
    endtask

    task automatic read_all_modes();
        for (int m = 0; m < 8; m++)
            step(1'b1, 16'h0, 16'h0, 1'b0, 1'b0, 1'b0, 2'b11, m[2], m[1], m[0], 1'b0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL R2 watchdog actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; op_a = '0; op_b = '0; a_signed = 1'b0; b_signed = 1'b0;
        frac_mode = 1'b0; acc_op = 2'b00; out_wide = 1'b0; rnd_en = 1'b0; sat_en = 1'b0;
        clr_ovf = 1'b0;
        m_acc = 0; m_res = '0; m_sat = 1'b0; m_ovf = 1'b0;
        p_vld = 1'b0; p_op = 2'b00; p_wide = 1'b0; p_rnd = 1'b0; p_sat = 1'b0; p_prod = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        cur_req = "R1";
        check_all();
        rst = 1'b0;

        // operand format and fractional sweep, back to back, cycling load/add/sub
        cur_req = "R2,R3,R4,R5,R12";
        for (int s = 0; s < 8; s++)
            for (int i = 0; i < 8; i++)
                for (int j = 0; j < 8; j++)
                    step(1'b1, pick(i), pick(j), s[0], s[1], s[2], 2'((i + j + s) % 3),
                         1'b1, 1'b0, 1'b0, 1'b0);
        idle(1'b1);

        // strobe low with changing inputs
        cur_req = "R6";
        for (int k = 0; k < 6; k++)
            step(1'b0, pick(k), pick(7 - k), k[0], k[1], 1'b0, 2'(k % 4), k[0], 1'b1, 1'b1, 1'b0);

        // extraction from many accumulator states
        cur_req = "R9,R10,R11,R12";
        for (int i = 0; i < 8; i++)
            for (int j = 0; j < 8; j++) begin
                step(1'b1, pick(i), pick(j), i[0], j[0], 1'b0, 2'((i + j) % 3),
                     1'b0, 1'b0, 1'b0, 1'b0);
                read_all_modes();
            end
        step(1'b1, 16'h8000, 16'h0001, 1'b0, 1'b0, 1'b0, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0);
        read_all_modes();
        step(1'b1, 16'h7FFF, 16'h7FFF, 1'b1, 1'b1, 1'b1, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0);
        step(1'b1, 16'h4000, 16'h0001, 1'b0, 1'b0, 1'b0, 2'b01, 1'b1, 1'b0, 1'b0, 1'b0);
        read_all_modes();

        // accumulator overflow: largest unsigned product added repeatedly
        cur_req = "R7";
        idle(1'b1);
        step(1'b1, 16'h0, 16'h0, 1'b0, 1'b0, 1'b0, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0);
        for (int k = 0; k < 140; k++) begin
            step(1'b1, 16'hFFFF, 16'hFFFF, 1'b0, 1'b0, 1'b0, 2'b01, 1'b1, 1'b0, 1'b1, 1'b0);
            if (k % 20 == 5) read_all_modes();
        end
        step(1'b1, 16'h0003, 16'h0005, 1'b1, 1'b1, 1'b0, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0);
        for (int k = 0; k < 140; k++) begin
            step(1'b1, 16'hFFFF, 16'hFFFF, 1'b0, 1'b0, 1'b0, 2'b10, 1'b1, 1'b0, 1'b1, 1'b0);
            if (k % 20 == 7) read_all_modes();
        end
        idle(1'b0);

        // clear, and overflow landing on the clear edge
        cur_req = "R8";
        idle(1'b1);
        idle(1'b0);
        step(1'b1, 16'h0, 16'h0, 1'b0, 1'b0, 1'b0, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0);
        for (int k = 0; k < 129; k++)
            step(1'b1, 16'hFFFF, 16'hFFFF, 1'b0, 1'b0, 1'b0, 2'b01, 1'b1, 1'b0, 1'b0, 1'b0);
        idle(1'b1);
        idle(1'b1);
        idle(1'b0);
        idle(1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule